// File: doc/BRIEF.md
# Memory-Mapped Character FIFO Port

This block is a bus-slave peripheral that moves 8-bit characters between an embedded processor and a byte stream on the host side. Software sees two 32-bit word registers. Writing the data word queues a character for the host. Reading the data word takes the oldest character the host sent and returns a flag that says whether a character was really there.

A receive FIFO and a transmit FIFO decouple the two sides. Each has its own depth parameter and its own interrupt threshold. On the host side, a valid/ready byte channel runs in each direction; it stands in for the debug-link transport. One level-sensitive, active-high interrupt output is formed from a read condition and a write condition, and software can mask each one separately.

Top module: `char_mmio_port`

## Requirements
- R1: A write to the data word (word address 0) pushes busWdata[7:0] into the transmit FIFO. The host sees these bytes on hostTxData/hostTxValid in write order, and each byte is removed on a cycle with hostTxReady high.
- R2: A host byte is accepted on a cycle with hostRxValid and hostRxReady both high. A data-word read then returns the oldest byte in bits 7:0 with bit 15 set to 1, and removes that byte.
- R3: A data-word read while the receive FIFO is empty returns bit 15 = 0 and bits 7:0 = 0, and leaves the FIFO unchanged.
- R4: Bits 31:16 of a data-word read give the number of characters still in the receive FIFO after that read.
- R5: A data-word write while the transmit FIFO is full is dropped. The FIFO contents and order are unchanged.
- R6: hostRxReady is low while the receive FIFO is full, and a byte offered then is not stored.
- R7: A read of the control word (word address 1) returns the read enable in bit 0, the write enable in bit 1, the read condition in bit 8, the write condition in bit 9, the transmit free-entry count in bits 31:16, and 0 in every other bit.
- R8: A control-word write updates only the two enables, from busWdata[0] and busWdata[1]. It has no effect on bits 8, 9 or 31:16.
- R9: The read condition is 1 when the receive fill is at least RX_DEPTH-RX_THRESH. If RX_THRESH is 0, it is 1 whenever the receive FIFO is not empty.
- R10: The write condition is 1 when the transmit free-entry count is at least TX_DEPTH-TX_THRESH.
- R11: irq is high exactly when (read condition AND read enable) OR (write condition AND write enable).
- R12: After reset both FIFOs are empty, both enables are 0, irq is low, hostTxValid is low and hostRxReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 1 | Word address: 0 selects data, 1 selects control |
| busRead | input | 1 | Read strobe; a data-word read removes a character |
| busWrite | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as busRead |
| irq | output | 1 | Level interrupt request, active high |
| hostRxData | input | 8 | Byte from the host |
| hostRxValid | input | 1 | Host byte offered |
| hostRxReady | output | 1 | Receive FIFO can accept a byte |
| hostTxData | output | 8 | Byte to the host |
| hostTxValid | output | 1 | Transmit FIFO has a byte |
| hostTxReady | input | 1 | Host takes the byte |

## Verification
A corrupted pointer or count shows up at once. The next data-word read returns the wrong character or the wrong remaining count in bits 31:16, and the next control read returns the wrong free count. A wrong count also moves the cycle on which a pending bit, and then irq, changes. The bench fills each FIFO one character at a time and checks the thresholds on the exact fill where the condition should flip. It then drains the FIFO and compares the whole sequence, so a lost, duplicated or reordered byte is reported within that drain.

// File: rtl/char_mmio_pkg.sv
package char_mmio_pkg;
  localparam int CHAR_W = 8;
  localparam int REG_W = 32;
  localparam int RVALID_BIT = 15;
  localparam int RE_BIT = 0;
  localparam int WE_BIT = 1;
  localparam int RPEND_BIT = 8;
  localparam int WPEND_BIT = 9;

  typedef struct packed {
    logic txPush;   // data write
    logic rxPop;    // data read
    logic enWrite;  // control write
    logic selCtrl;  // read mux selects control word
  } regStrobe_t;
endpackage

// File: rtl/char_fifo.sv
module char_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign doPush = push && !full;
  assign doPop = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop) count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/char_mmio_ctrl.sv
module char_mmio_ctrl
  import char_mmio_pkg::*;
(
  input  logic       busAddr,
  input  logic       busRead,
  input  logic       busWrite,
  output regStrobe_t strb
);
  always_comb begin
    strb.txPush = busWrite && !busAddr;
    strb.rxPop = busRead && !busAddr;
    strb.enWrite = busWrite && busAddr;
    strb.selCtrl = busAddr;
  end
endmodule

// File: rtl/char_mmio_dp.sv
module char_mmio_dp
  import char_mmio_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int RX_THRESH = 8,
  parameter int TX_THRESH = 8,
  localparam int RXC = $clog2(RX_DEPTH + 1),
  localparam int TXC = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              irq,
  input  logic [CHAR_W-1:0] hostRxData,
  input  logic              hostRxValid,
  output logic              hostRxReady,
  output logic [CHAR_W-1:0] hostTxData,
  output logic              hostTxValid,
  input  logic              hostTxReady,
  output logic [RXC-1:0]    rxCount,
  output logic [TXC-1:0]    txCount
);
  localparam logic [RXC-1:0] RX_LIMIT = RXC'(RX_DEPTH - RX_THRESH);
  localparam logic [TXC-1:0] TX_LIMIT = TXC'(TX_DEPTH - TX_THRESH);

  logic [CHAR_W-1:0] rxHead;
  logic rxFull, rxEmpty, txFull, txEmpty;
  logic rdEn, wrEn, rdPend, wrPend;
  logic [TXC-1:0] txFree;
  logic [RXC-1:0] rxAfter;

  char_fifo #(.DEPTH(RX_DEPTH), .WIDTH(CHAR_W)) uRxFifo (
    .clk(clk), .rstN(rstN),
    .push(hostRxValid), .pushData(hostRxData),
    .pop(strb.rxPop), .headData(rxHead),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  char_fifo #(.DEPTH(TX_DEPTH), .WIDTH(CHAR_W)) uTxFifo (
    .clk(clk), .rstN(rstN),
    .push(strb.txPush), .pushData(busWdata[CHAR_W-1:0]),
    .pop(hostTxReady), .headData(hostTxData),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  assign hostRxReady = !rxFull;
  assign hostTxValid = !txEmpty;
  assign txFree = TXC'(TX_DEPTH) - txCount;
  assign rxAfter = rxEmpty ? '0 : rxCount - 1'b1;

  generate
    if (RX_THRESH == 0) begin : gRdAny
      assign rdPend = !rxEmpty;
    end else begin : gRdLevel
      assign rdPend = (rxCount >= RX_LIMIT);
    end
  endgenerate
  assign wrPend = (txFree >= TX_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEn <= 1'b0;
      wrEn <= 1'b0;
    end else if (strb.enWrite) begin
      rdEn <= busWdata[RE_BIT];
      wrEn <= busWdata[WE_BIT];
    end
  end

  assign irq = (rdPend && rdEn) || (wrPend && wrEn);

  always_comb begin
    busRdata = '0;
    if (strb.selCtrl) begin
      busRdata[RE_BIT] = rdEn;
      busRdata[WE_BIT] = wrEn;
      busRdata[RPEND_BIT] = rdPend;
      busRdata[WPEND_BIT] = wrPend;
      busRdata[31:16] = 16'(txFree);
    end else begin
      busRdata[RVALID_BIT] = !rxEmpty;
      busRdata[CHAR_W-1:0] = rxEmpty ? '0 : rxHead;
      busRdata[31:16] = 16'(rxAfter);
    end
  end
endmodule

// File: rtl/char_mmio_port.sv
module char_mmio_port #(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int RX_THRESH = 8,
  parameter int TX_THRESH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busAddr,
  input  logic        busRead,
  input  logic        busWrite,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq,
  input  logic [7:0]  hostRxData,
  input  logic        hostRxValid,
  output logic        hostRxReady,
  output logic [7:0]  hostTxData,
  output logic        hostTxValid,
  input  logic        hostTxReady
);
  localparam int RXC = $clog2(RX_DEPTH + 1);
  localparam int TXC = $clog2(TX_DEPTH + 1);

  char_mmio_pkg::regStrobe_t strb;
  logic [RXC-1:0] rxCount;
  logic [TXC-1:0] txCount;

  char_mmio_ctrl uCtrl (
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite), .strb(strb)
  );

  char_mmio_dp #(
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH),
    .RX_THRESH(RX_THRESH), .TX_THRESH(TX_THRESH)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq),
    .hostRxData(hostRxData), .hostRxValid(hostRxValid), .hostRxReady(hostRxReady),
    .hostTxData(hostTxData), .hostTxValid(hostTxValid), .hostTxReady(hostTxReady),
    .rxCount(rxCount), .txCount(txCount)
  );
endmodule

// File: rtl/char_mmio_port_chk.sv
module char_mmio_port_chk #(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  localparam int RXC = $clog2(RX_DEPTH + 1),
  localparam int TXC = $clog2(TX_DEPTH + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic           busAddr,
  input logic           busRead,
  input logic           busWrite,
  input logic [31:0]    busWdata,
  input logic [31:0]    busRdata,
  input logic           irq,
  input logic           hostRxValid,
  input logic           hostRxReady,
  input logic           hostTxValid,
  input logic           hostTxReady,
  input logic [RXC-1:0] rxCount,
  input logic [TXC-1:0] txCount
);
  assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !busAddr && !busRdata[15]) |-> (busRdata[7:0] == 8'h00));

  assert_pop_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !busAddr && busRdata[15] && !(hostRxValid && hostRxReady))
      |=> (rxCount == $past(rxCount) - 1'b1));

  assert_tx_full_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !busAddr && txCount == TXC'(TX_DEPTH) && !(hostTxValid && hostTxReady))
      |=> $stable(txCount));

  assert_rx_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostRxValid && !hostRxReady && !(busRead && !busAddr)) |=> $stable(rxCount));

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr && busWdata[1:0] == 2'b00) |=> !irq);
endmodule

bind char_mmio_port char_mmio_port_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
  .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
  .hostRxValid(hostRxValid), .hostRxReady(hostRxReady),
  .hostTxValid(hostTxValid), .hostTxReady(hostTxReady),
  .rxCount(rxCount), .txCount(txCount)
);

// File: tb/tb_char_mmio_port.sv
`timescale 1ns/1ps
module tb_char_mmio_port;
  localparam int RXD = 16;
  localparam int TXD = 16;
  localparam int RXT = 4;
  localparam int TXT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busAddr = 1'b0, busRead = 1'b0, busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq;
  logic [7:0] hostRxData = '0;
  logic hostRxValid = 1'b0;
  logic hostRxReady;
  logic [7:0] hostTxData;
  logic hostTxValid;
  logic hostTxReady = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  char_mmio_port #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .RX_THRESH(RXT), .TX_THRESH(TXT)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .hostRxData(hostRxData), .hostRxValid(hostRxValid), .hostRxReady(hostRxReady),
    .hostTxData(hostTxData), .hostTxValid(hostTxValid), .hostTxReady(hostTxReady)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrlWord(int txFill, int rxFill, bit re, bit we);
    logic [31:0] w = '0;
    w[31:16] = 16'(TXD - txFill);
    w[9] = (TXD - txFill) >= (TXD - TXT);
    w[8] = rxFill >= (RXD - RXT);
    w[1] = we;
    w[0] = re;
    return w;
  endfunction

  task automatic busRd(input logic a, output logic [31:0] d);
    @(negedge clk);
    busRead = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic busWr(input logic a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic hostSend(input logic [7:0] b);
    @(negedge clk);
    hostRxValid = 1'b1; hostRxData = b;
    @(negedge clk);
    hostRxValid = 1'b0;
  endtask

  task automatic hostTake(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk({req, " tx valid"}, 32'(hostTxValid), 32'd1);
    chk({req, " tx byte"}, 32'(hostTxData), 32'(exp));
    hostTxReady = 1'b1;
    @(negedge clk);
    hostTxReady = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    @(negedge clk);
    chk("R12 irq", 32'(irq), 32'd0);
    chk("R12 txValid", 32'(hostTxValid), 32'd0);
    chk("R12 rxReady", 32'(hostRxReady), 32'd1);
    busRd(1'b1, d);
    chk("R7 R12 R10 ctrl at reset", d, ctrlWord(0, 0, 0, 0));
  endtask

  task automatic testEmptyRead();
    logic [31:0] d;
    busRd(1'b0, d);
    chk("R3 empty read", d, 32'h0000_0000);
  endtask

  task automatic testTxOrder();
    busWr(1'b0, 32'hFFFF_FF41);
    busWr(1'b0, 32'h0000_0042);
    busWr(1'b0, 32'h1234_5643);
    hostTake("R1", 8'h41);
    hostTake("R1", 8'h42);
    hostTake("R1", 8'h43);
    @(negedge clk);
    chk("R1 tx drained", 32'(hostTxValid), 32'd0);
  endtask

  task automatic testRxPop();
    logic [31:0] d;
    hostSend(8'h11);
    hostSend(8'h22);
    hostSend(8'h33);
    busRd(1'b0, d);
    chk("R2 R4 first pop", d, 32'h0002_8011);
    busRd(1'b0, d);
    chk("R2 R4 second pop", d, 32'h0001_8022);
    busRd(1'b0, d);
    chk("R2 R4 third pop", d, 32'h0000_8033);
    busRd(1'b0, d);
    chk("R3 read after drain", d, 32'h0000_0000);
  endtask

  task automatic testTxFull();
    logic [31:0] d;
    busWr(1'b1, 32'h0000_0002);
    for (int i = 0; i < TXD; i++) begin
      busWr(1'b0, 32'(i));
      if (i == TXT - 1) begin
        busRd(1'b1, d);
        chk("R10 write cond at limit", d, ctrlWord(TXT, 0, 0, 1));
        @(negedge clk);
        chk("R11 irq write enabled", 32'(irq), 32'd1);
      end
      if (i == TXT) begin
        busRd(1'b1, d);
        chk("R10 write cond below limit", d, ctrlWord(TXT + 1, 0, 0, 1));
        @(negedge clk);
        chk("R11 irq cond low", 32'(irq), 32'd0);
      end
    end
    busWr(1'b0, 32'h0000_00EE);
    busRd(1'b1, d);
    chk("R5 free count full", d, ctrlWord(TXD, 0, 0, 1));
    for (int i = 0; i < TXD; i++) hostTake("R5", 8'(i));
    @(negedge clk);
    chk("R5 dropped byte absent", 32'(hostTxValid), 32'd0);
    busWr(1'b1, 32'h0000_0000);
  endtask

  task automatic testRxFull();
    logic [31:0] d;
    busWr(1'b1, 32'h0000_0001);
    for (int i = 0; i < RXD; i++) begin
      hostSend(8'(8'h40 + i));
      if (i == RXD - RXT - 2) begin
        busRd(1'b1, d);
        chk("R9 read cond below", d, ctrlWord(0, RXD - RXT - 1, 1, 0));
        @(negedge clk);
        chk("R11 irq read below", 32'(irq), 32'd0);
      end
      if (i == RXD - RXT - 1) begin
        busRd(1'b1, d);
        chk("R9 read cond at limit", d, ctrlWord(0, RXD - RXT, 1, 0));
        @(negedge clk);
        chk("R11 irq read enabled", 32'(irq), 32'd1);
      end
    end
    @(negedge clk);
    chk("R6 ready low when full", 32'(hostRxReady), 32'd0);
    hostSend(8'h99);
    for (int i = 0; i < RXD; i++) begin
      busRd(1'b0, d);
      chk("R6 R2 drain", d, {16'(RXD - 1 - i), 16'h8000 | 16'(8'h40 + i)});
    end
    busRd(1'b0, d);
    chk("R6 extra byte not stored", d, 32'h0000_0000);
    busWr(1'b1, 32'h0000_0000);
  endtask

  task automatic testCtrlWrite();
    logic [31:0] d;
    busWr(1'b0, 32'h0000_0055);
    busWr(1'b1, 32'hFFFF_FFFF);
    busRd(1'b1, d);
    chk("R8 only enables change", d, ctrlWord(1, 0, 1, 1));
    busWr(1'b1, 32'h0000_0302);
    busRd(1'b1, d);
    chk("R8 write enable only", d, ctrlWord(1, 0, 0, 1));
    @(negedge clk);
    chk("R11 irq from write cond", 32'(irq), 32'd1);
    busWr(1'b1, 32'h0000_0000);
    @(negedge clk);
    chk("R11 irq masked", 32'(irq), 32'd0);
    hostTake("R8", 8'h55);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEmptyRead();
    testTxOrder();
    testRxPop();
    testTxFull();
    testRxFull();
    testCtrlWrite();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule